// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block gathers 39 maskable request lines from on-chip peripherals, resynchronises each one and turns it into a pending flag. An edge on the line sets a flag that stays set. On port sources configured for level mode, the flag instead follows the line. Each flag is gated by an enable bit. Among the enabled sources that are routed to the CPU, the lowest source index wins. The block presents the winner's vector number and its vector-table address on a registered request/acknowledge handshake.

Vector numbers run from 16 to 71 and skip reserved holes. Most sources also own a fixed channel on an intelligent DMA engine. For those sources a route bit sends the request to that channel instead of the CPU, and the channel's acknowledge clears the flag. Port inputs and key inputs can choose a trigger polarity. Only port inputs can also select level triggering.

Top module: `fpv_intc`

## Requirements
- R1: After reset, `cpu_irq`, `vec_num`, `vec_addr` and `dma_req` are zero, and every register (addresses 0 to 4) reads as zero.
- R2: Source index i maps to a vector number v as follows: 0..10 -> 16..26; 11..22 -> 30,31,34,35,...,50,51 (pairs, step 4); 23..26 -> 52..55; 27..29 -> 56..58; 30..32 -> 60..62; 33,34 -> 64,65; 35..38 -> 68..71. `vec_addr` = VEC_BASE + 4*v.
- R3: When several enabled, CPU-routed sources are pending, the one with the lowest index is presented.
- R4: A pending source whose enable bit (address 0, bit i) is 0 raises no request, yet its flag reads as 1 at address 1.
- R5: An edge flag stays set after the input returns inactive. Writing 1 to bit i at address 1 clears it.
- R6: Port sources (indices 0..3 and 35..38) trigger on a level when bit i at address 3 is 1, and on an edge when it is 0. Bit i at address 4 set to 1 selects falling edge or low level. A level flag follows the input and ignores write-1-to-clear.
- R7: Key sources (indices 4 and 5) accept the polarity bit but not the level bit. All other sources trigger on a rising edge only. Level bits read back only for port sources; polarity bits read back only for port and key sources.
- R8: A source with a DMA channel and its route bit (address 2, bit i) set, if enabled and pending, drives `dma_req[c]` and does not drive `cpu_irq`. The channel c counts up from 1 over the indices that have a channel.
- R9: Sources 4, 5, 8, 9, 10, 27, 30 and 34 have no channel. Their route bit reads back 0 and they always use the CPU path.
- R10: A pulse on `dma_ack[c]` clears the edge flag of the source mapped to channel c.
- R11: Once `cpu_irq` is high, it and `vec_num`/`vec_addr` hold their values until a cycle with `cpu_ack` high. On that cycle they reload from the current pending state.
- R12: A rising edge applied before clock edge 1 becomes readable as pending after edge 3. It reaches `cpu_irq` after edge 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| src_req | input | 39 | raw peripheral request lines, bit i = source i |
| reg_we | input | 1 | register write strobe |
| reg_addr | input | 3 | register select: 0 enable, 1 pending (W1C), 2 route, 3 level, 4 polarity |
| reg_wdata | input | 39 | write data, bit per source |
| reg_rdata | output | 39 | combinational read data for `reg_addr` |
| cpu_irq | output | 1 | interrupt request to CPU |
| cpu_ack | input | 1 | CPU acknowledge, releases the held vector |
| vec_num | output | 7 | vector number of the presented source |
| vec_addr | output | 32 | vector table entry address |
| dma_req | output | 31 | DMA channel requests, channels 1..31 |
| dma_ack | input | 31 | DMA channel acknowledges, channels 1..31 |

## Verification
The hardest case to reach from the ports is the ordered drain of all 39 sources. Every line must be pending at once, and every acknowledge must land only after the previous flag has been cleared, because the registered vector otherwise reloads the old winner. The bench raises all lines together and then walks the list in steps: clear the presented flag, wait one cycle, acknowledge. At each step it compares the presented vector with a value it derives by counting non-reserved vector numbers upward from 16. A separate sweep reaches each DMA channel, which requires the route and enable registers to be loaded together, and checks that the CPU path stays silent.

// File: rtl/fpv_pkg.sv
package fpv_pkg;
  localparam int NSRC = 39;
  localparam int NCH  = 32;
  localparam int IW   = 6;
  localparam int VW   = 7;

  // sparse vector number of a source index
  function automatic int src_vec(input int i);
    int k;
    if (i <= 10) return 16 + i;
    if (i <= 22) begin
      k = i - 11;
      return 30 + (k / 2) * 4 + (k % 2);
    end
    if (i <= 26) return 52 + (i - 23);
    if (i <= 29) return 56 + (i - 27);
    if (i <= 32) return 60 + (i - 30);
    if (i <= 34) return 64 + (i - 33);
    return 68 + (i - 35);
  endfunction

  // DMA channel of a source, 0 = none
  function automatic int src_chan(input int i);
    if (i <= 3) return i + 1;
    if (i == 6 || i == 7) return i - 1;
    if (i >= 11 && i <= 26) return i - 4;
    if (i == 28 || i == 29) return i - 5;
    if (i == 31 || i == 32) return i - 6;
    if (i == 33) return 27;
    if (i >= 35) return i - 7;
    return 0;
  endfunction

  function automatic int chan_src(input int c);
    for (int s = 0; s < NSRC; s++)
      if (src_chan(s) == c) return s;
    return 0;
  endfunction

  function automatic logic [NSRC-1:0] port_mask();
    logic [NSRC-1:0] m;
    for (int s = 0; s < NSRC; s++) m[s] = (s <= 3) || (s >= 35);
    return m;
  endfunction

  function automatic logic [NSRC-1:0] key_mask();
    logic [NSRC-1:0] m;
    for (int s = 0; s < NSRC; s++) m[s] = (s == 4) || (s == 5);
    return m;
  endfunction

  function automatic logic [NSRC-1:0] chan_mask();
    logic [NSRC-1:0] m;
    for (int s = 0; s < NSRC; s++) m[s] = (src_chan(s) != 0);
    return m;
  endfunction

  function automatic logic [31:0] vec_addr_of(input logic [31:0] base, input logic [VW-1:0] v);
    return base + {23'd0, v, 2'b00};
  endfunction
endpackage

// File: rtl/fpv_trigger.sv
module fpv_trigger (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic invert,
  output logic evt,
  output logic act
);
  logic s1, s2, act_prev;

  assign act = s2 ^ invert;
  assign evt = act & ~act_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      act_prev <= 1'b0;
    end else begin
      s1 <= raw;
      s2 <= s1;
      act_prev <= act;
    end
  end

  // R12
  evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);
endmodule

// File: rtl/fpv_flags.sv
module fpv_flags #(
  parameter int N = 39
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_evt,
  input  logic [N-1:0] lvl_act,
  input  logic [N-1:0] lvl_mode,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           flag[g] <= 1'b0;
      else if (lvl_mode[g]) flag[g] <= lvl_act[g];
      else                  flag[g] <= set_evt[g] | (flag[g] & ~clr[g]);
    end
  end

  logic [N-1:0] edge_clr;
  assign edge_clr = clr & ~set_evt & ~lvl_mode;

  // R5
  edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|edge_clr) |=> ((flag & $past(edge_clr) & ~lvl_mode) == '0));
endmodule

// File: rtl/fpv_select.sv
module fpv_select #(
  parameter int N  = 39,
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  cand,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end

  logic [N-1:0] below;
  assign below = (N'(1) << idx) - N'(1);

  // R3
  lowest_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> (cand[idx] && ((cand & below) == '0)));
endmodule

// File: rtl/fpv_intc.sv
module fpv_intc #(
  parameter logic [31:0] VEC_BASE = 32'h0000_0C00
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [fpv_pkg::NSRC-1:0]   src_req,
  input  logic                       reg_we,
  input  logic [2:0]                 reg_addr,
  input  logic [fpv_pkg::NSRC-1:0]   reg_wdata,
  output logic [fpv_pkg::NSRC-1:0]   reg_rdata,
  output logic                       cpu_irq,
  input  logic                       cpu_ack,
  output logic [fpv_pkg::VW-1:0]     vec_num,
  output logic [31:0]                vec_addr,
  output logic [fpv_pkg::NCH-1:1]    dma_req,
  input  logic [fpv_pkg::NCH-1:1]    dma_ack
);
  import fpv_pkg::*;

  localparam logic [NSRC-1:0] LVL_OK = port_mask();
  localparam logic [NSRC-1:0] POL_OK = port_mask() | key_mask();
  localparam logic [NSRC-1:0] RT_OK  = chan_mask();

  logic [NSRC-1:0] en_q, route_q, lvl_q, pol_q;
  logic [NSRC-1:0] evt, act, flag, clr, w1c, cand;
  logic            any;
  logic [IW-1:0]   idx;

  // register file
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0; route_q <= '0; lvl_q <= '0; pol_q <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        3'd0: en_q    <= reg_wdata;
        3'd2: route_q <= reg_wdata & RT_OK;
        3'd3: lvl_q   <= reg_wdata & LVL_OK;
        3'd4: pol_q   <= reg_wdata & POL_OK;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0: reg_rdata = en_q;
      3'd1: reg_rdata = flag;
      3'd2: reg_rdata = route_q;
      3'd3: reg_rdata = lvl_q;
      3'd4: reg_rdata = pol_q;
      default: reg_rdata = '0;
    endcase
  end

  assign w1c = (reg_we && reg_addr == 3'd1) ? reg_wdata : '0;

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    localparam int C = src_chan(g);
    fpv_trigger u_trig (
      .clk(clk), .rst_n(rst_n), .raw(src_req[g]), .invert(pol_q[g]),
      .evt(evt[g]), .act(act[g])
    );
    if (C != 0) begin : g_dma
      assign clr[g] = w1c[g] | dma_ack[C];
    end else begin : g_cpu
      assign clr[g] = w1c[g];
    end
  end

  for (genvar c = 1; c < NCH; c++) begin : g_chan
    localparam int S = chan_src(c);
    assign dma_req[c] = flag[S] & en_q[S] & route_q[S];
  end

  fpv_flags #(.N(NSRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_evt(evt), .lvl_act(act),
    .lvl_mode(lvl_q), .clr(clr), .flag(flag)
  );

  assign cand = flag & en_q & ~route_q;

  fpv_select #(.N(NSRC), .IW(IW)) u_sel (
    .clk(clk), .rst_n(rst_n), .cand(cand), .any(any), .idx(idx)
  );

  // registered vector, frozen while a request is outstanding
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_irq  <= 1'b0;
      vec_num  <= '0;
      vec_addr <= '0;
    end else if (!cpu_irq || cpu_ack) begin
      cpu_irq  <= any;
      vec_num  <= any ? VW'(src_vec(int'(idx))) : '0;
      vec_addr <= any ? vec_addr_of(VEC_BASE, VW'(src_vec(int'(idx)))) : '0;
    end
  end

  // R11
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_irq && !cpu_ack) |=> (cpu_irq && $stable(vec_num) && $stable(vec_addr)));

  // R2
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> (vec_num >= 7'd16 && vec_num <= 7'd71));

  // R8
  dma_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dma_req) <= $countones(flag & route_q));
endmodule

// File: tb/sim_fpv_intc.sv
module sim_fpv_intc;
  localparam int CLK_PERIOD = 10;
  localparam int N = 39;
  localparam logic [31:0] BASE = 32'h0000_0C00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] src_req = '0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [N-1:0] reg_wdata = '0;
  logic [N-1:0] reg_rdata;
  logic cpu_irq;
  logic cpu_ack = 1'b0;
  logic [6:0] vec_num;
  logic [31:0] vec_addr;
  logic [31:1] dma_req;
  logic [31:1] dma_ack = '0;

  int nchk = 0;
  int nerr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fpv_intc #(.VEC_BASE(BASE)) u0 (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_irq(cpu_irq), .cpu_ack(cpu_ack), .vec_num(vec_num),
    .vec_addr(vec_addr), .dma_req(dma_req), .dma_ack(dma_ack)
  );

  function automatic bit reserved(input int v);
    return (v >= 27 && v <= 29) || v == 32 || v == 33 || v == 36 || v == 37 ||
           v == 40 || v == 41 || v == 44 || v == 45 || v == 48 || v == 49 ||
           v == 59 || v == 63 || v == 66 || v == 67;
  endfunction

  function automatic int exp_vec(input int k);
    int v = 15;
    int n = -1;
    while (n < k) begin
      v++;
      if (!reserved(v)) n++;
    end
    return v;
  endfunction

  function automatic bit nochan(input int k);
    return k == 4 || k == 5 || k == 8 || k == 9 || k == 10 ||
           k == 27 || k == 30 || k == 34;
  endfunction

  function automatic int exp_chan(input int k);
    int c = 0;
    if (nochan(k)) return 0;
    for (int j = 0; j <= k; j++) if (!nochan(j)) c++;
    return c;
  endfunction

  function automatic logic [N-1:0] bit_of(input int k);
    return N'(1) << k;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic ack_pulse();
    cpu_ack = 1'b1;
    tick(1);
    cpu_ack = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL R11 watchdog expired actual=0 expected=1");
    $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
    $finish;
  end

  initial begin
    logic [N-1:0] d, pm, km, cm;
    pm = '0; km = '0; cm = '0;
    for (int k = 0; k < N; k++) begin
      if (k < 4 || k > 34) pm[k] = 1'b1;
      if (k == 4 || k == 5) km[k] = 1'b1;
      if (!nochan(k)) cm[k] = 1'b1;
    end

    tick(3);
    // R1 reset state
    chk(cpu_irq == 0 && vec_num == 0 && vec_addr == 0 && dma_req == 0, "R1 outputs",
        {cpu_irq, vec_num, vec_addr}, 0);
    rst_n = 1'b1;
    tick(1);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), d);
      chk(d == 0, "R1 register", d, 0);
    end

    // per-source sweep: R2, R4, R5, R11, R12
    for (int k = 0; k < N; k++) begin
      src_req[k] = 1'b1;
      tick(2);
      rd(3'd1, d);
      if (k == 0) chk(d[k] == 0, "R12 not yet pending", d, 0);
      tick(1);
      rd(3'd1, d);
      chk(d[k] == 1, "R4 flag set while disabled", d, bit_of(k));
      tick(1);
      chk(cpu_irq == 0, "R4 disabled no request", cpu_irq, 0);
      src_req[k] = 1'b0;
      wr(3'd0, bit_of(k));
      tick(1);
      chk(cpu_irq == 1 && vec_num == 7'(exp_vec(k)), "R2 vector number", vec_num, exp_vec(k));
      chk(vec_addr == BASE + 32'(4 * exp_vec(k)), "R2 vector address", vec_addr, BASE + 32'(4 * exp_vec(k)));
      tick(3);
      rd(3'd1, d);
      chk(d[k] == 1, "R5 flag sticky", d, bit_of(k));
      wr(3'd1, bit_of(k));
      rd(3'd1, d);
      chk(d[k] == 0, "R5 W1C clears", d, 0);
      chk(cpu_irq == 1 && vec_num == 7'(exp_vec(k)), "R11 held until ack", vec_num, exp_vec(k));
      ack_pulse();
      chk(cpu_irq == 0, "R11 release on ack", cpu_irq, 0);
      wr(3'd0, '0);
      tick(2);
    end

    // priority drain: R3
    src_req = '1;
    wr(3'd0, '1);
    tick(5);
    for (int k = 0; k < N; k++) begin
      chk(cpu_irq == 1 && vec_num == 7'(exp_vec(k)), "R3 priority order", vec_num, exp_vec(k));
      wr(3'd1, bit_of(k));
      ack_pulse();
    end
    chk(cpu_irq == 0, "R3 drained", cpu_irq, 0);
    src_req = '0;
    wr(3'd0, '0);
    tick(4);
    rd(3'd1, d);
    chk(d == 0, "R7 falling edge ignored on rising sources", d, 0);

    // port modes on source 36: R6
    wr(3'd3, bit_of(36));
    src_req[36] = 1'b1;
    tick(4);
    rd(3'd1, d);
    chk(d[36] == 1, "R6 high level pending", d, bit_of(36));
    wr(3'd1, bit_of(36));
    tick(1);
    rd(3'd1, d);
    chk(d[36] == 1, "R6 level ignores W1C", d, bit_of(36));
    src_req[36] = 1'b0;
    tick(4);
    rd(3'd1, d);
    chk(d[36] == 0, "R6 level follows input", d, 0);
    wr(3'd4, bit_of(36));
    tick(3);
    rd(3'd1, d);
    chk(d[36] == 1, "R6 low level pending", d, bit_of(36));
    src_req[36] = 1'b1;
    tick(4);
    rd(3'd1, d);
    chk(d[36] == 0, "R6 low level released", d, 0);
    wr(3'd3, '0);
    tick(2);
    wr(3'd1, '1);
    tick(2);
    rd(3'd1, d);
    chk(d[36] == 0, "R6 falling edge idle", d, 0);
    src_req[36] = 1'b0;
    tick(4);
    rd(3'd1, d);
    chk(d[36] == 1, "R6 falling edge pending", d, bit_of(36));
    wr(3'd4, '0);
    tick(3);
    wr(3'd1, '1);

    // key and fixed sources: R7
    wr(3'd3, '1);
    rd(3'd3, d);
    chk(d == pm, "R7 level bits port only", d, pm);
    wr(3'd4, '1);
    rd(3'd4, d);
    chk(d == (pm | km), "R7 polarity bits port and key", d, pm | km);
    tick(3);
    wr(3'd1, '1);
    tick(4);
    rd(3'd1, d);
    chk(d[4] == 0, "R7 key has no level mode", d, 0);
    src_req[4] = 1'b1;
    tick(4);
    rd(3'd1, d);
    chk(d[4] == 0, "R7 key inverted ignores rise", d, 0);
    src_req[4] = 1'b0;
    tick(4);
    rd(3'd1, d);
    chk(d[4] == 1, "R7 key falling edge", d, 1 << 4);
    wr(3'd3, '0);
    wr(3'd4, '0);
    tick(3);
    wr(3'd1, '1);
    tick(1);
    rd(3'd1, d);
    chk(d == 0, "R7 cleanup", d, 0);

    // DMA path: R8, R9, R10
    wr(3'd2, '1);
    rd(3'd2, d);
    chk(d == cm, "R9 route bits only for channel sources", d, cm);
    wr(3'd0, '1);
    for (int k = 0; k < N; k++) begin
      if (!nochan(k)) begin
        int c;
        c = exp_chan(k);
        src_req[k] = 1'b1;
        tick(4);
        chk({dma_req, 1'b0} == (32'd1 << c), "R8 channel request", {dma_req, 1'b0}, 32'd1 << c);
        chk(cpu_irq == 0, "R8 no cpu request", cpu_irq, 0);
        dma_ack[c] = 1'b1;
        tick(1);
        dma_ack = '0;
        rd(3'd1, d);
        chk(d[k] == 0 && dma_req == 0, "R10 dma ack clears", d, 0);
        src_req[k] = 1'b0;
        tick(2);
      end
    end
    src_req[9] = 1'b1;
    tick(5);
    chk(cpu_irq == 1 && vec_num == 7'(exp_vec(9)) && dma_req == 0, "R9 no channel uses cpu",
        vec_num, exp_vec(9));
    wr(3'd1, '1);
    ack_pulse();
    chk(cpu_irq == 0, "R9 released", cpu_irq, 0);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule